// File: doc/BRIEF.md
# Random Sign Descrambler for Interleaved FFT Output

This block sits after an FFT whose inputs were randomly sign-flipped, one pseudo-random sequence per input channel. It removes those sign flips. The FFT output interleaves the two channels in time. Each valid word carries two consecutive samples of one channel: the real port holds the even sample and the imaginary port holds the odd one. Words alternate between channel a and channel b. Inside the block, a copy of each channel's sign sequence is kept. Both copies step and reseed exactly as the scrambler's do, and the matching sign bit is applied to each port.

Sequencing comes from the input valid strobe alone. Valid may drop for any number of cycles, and every piece of state freezes while it is low. There is no ready signal and so no back-pressure: the producer presents a word whenever valid is high, and the block always accepts it. A word leaves one cycle later with out_valid high. An enable input selects between descrambling and a plain pass-through. The sign sequences keep stepping on every valid word whatever the enable level, so they stay aligned with the scrambler.

Top module: `rand_sign_descrambler`

## Requirements
- R1: While rst_n is low, and at the first clock edge with rst_n low, out_valid, out_re and out_im become 0 and the channel flag is cleared. The first valid word after reset therefore belongs to channel a.
- R2: out_valid equals in_valid delayed by exactly one clock cycle. The data of a word appears on out_re/out_im in the same cycle as its out_valid.
- R3: Valid words alternate channels, counting from 0 after reset. Even-numbered words use channel a's sequence and odd-numbered words use channel b's.
- R4: Each channel's sequence is a 16-bit shift register. Its feedback bit is the XOR of state bits 15, 13, 12 and 10. One step shifts the state left and inserts the feedback bit at bit 0. For a word of that channel, bit 15 of the current state is the sign for out_re and bit 14 is the sign for out_im, where 1 means negate. The state then advances two steps.
- R5: After reset, channel a starts from state 16'hACE1 and channel b starts from 16'h1D2B.
- R6: Each channel counts its samples, two per word. The sign sequence is reseeded to its start state in place of the two-step advance on the word that completes SYNC_SAMPLES samples. SYNC_SAMPLES must be even.
- R7: A cycle with in_valid low changes nothing. The channel flag, both sequence states, the sample counters and out_re/out_im all hold their values.
- R8: With en low on a valid word, out_re/out_im equal the inputs unchanged. The sign sequences still advance for that word.
- R9: Negation is two's complement with wraparound. The most negative value maps to itself.
- R10: A word stream built by applying the same sign sequences to original samples comes back as the original samples when en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | 1 = descramble, 0 = pass data through unchanged |
| in_valid | input | 1 | A word is present on in_re/in_im |
| in_re | input | DATA_W | Even sample of the current channel (two's complement) |
| in_im | input | DATA_W | Odd sample of the current channel (two's complement) |
| out_valid | output | 1 | Registered copy of in_valid |
| out_re | output | DATA_W | Descrambled even sample |
| out_im | output | DATA_W | Descrambled odd sample |

## Verification
The hardest case to reach from the ports is a reseed boundary that falls on a channel-b word, right after a gap or after words sent with enable low. A reseed on the wrong channel, or a count that also runs on idle cycles, only shows up after several reseed periods. The bench builds the design with a reseed interval of twelve samples. It then runs hundreds of words with a periodic gap pattern and an enable-off stretch, so that every reseed phase meets gaps and both channels. Original values are swept over the whole 8-bit range on both ports, and the most negative code is sent on its own.

// File: rtl/desc_pkg.sv
package desc_pkg;

  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;

  typedef struct packed {
    logic hi;   // sign applied to the even sample (real port)
    logic lo;   // sign applied to the odd sample (imag port)
  } sign_pair_t;

endpackage

// File: rtl/desc_sign_gen.sv
module desc_sign_gen #(
  parameter int                LFSR_W       = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK     = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED         = 16'hACE1,
  parameter int                SYNC_SAMPLES = 1024
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  output desc_pkg::sign_pair_t  sign
);
  localparam int CNT_W = $clog2(SYNC_SAMPLES);

  logic [LFSR_W-1:0] state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wrap;

  function automatic logic [LFSR_W-1:0] step1(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], ^(s & TAP_MASK)};
  endfunction

  assign wrap = (cnt_q == CNT_W'(SYNC_SAMPLES - 2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEED;
      cnt_q   <= '0;
    end else if (adv) begin
      if (wrap) begin
        state_q <= SEED;
        cnt_q   <= '0;
      end else begin
        state_q <= step1(step1(state_q));
        cnt_q   <= cnt_q + CNT_W'(2);
      end
    end
  end

  assign sign.hi = state_q[LFSR_W-1];
  assign sign.lo = state_q[LFSR_W-2];

  // R7: no movement without a word for this channel
  a_r7_seq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(state_q) && $stable(cnt_q)));

  // R6: sample count stays even and inside the interval
  a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[0] == 1'b0) && (int'(cnt_q) < SYNC_SAMPLES));

  // R5: a nonzero seed never leads to the all-zero lockup state
  a_r5_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

endmodule

// File: rtl/desc_cond_neg.sv
module desc_cond_neg #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] din,
  input  logic              flip,
  output logic [DATA_W-1:0] dout
);
  // two's complement, wraps: most negative value maps to itself
  assign dout = flip ? (~din + DATA_W'(1)) : din;
endmodule

// File: rtl/rand_sign_descrambler.sv
module rand_sign_descrambler #(
  parameter int                DATA_W       = 16,
  parameter int                LFSR_W       = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK     = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED_A       = 16'hACE1,
  parameter logic [LFSR_W-1:0] SEED_B       = 16'h1D2B,
  parameter int                SYNC_SAMPLES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_re,
  input  logic [DATA_W-1:0] in_im,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_re,
  output logic [DATA_W-1:0] out_im
);
  import desc_pkg::*;

  localparam int NUM_CH   = 2;
  localparam int NUM_LANE = 2;

  chan_e       chan_q;
  sign_pair_t  sgn [NUM_CH];
  sign_pair_t  sel;
  logic [DATA_W-1:0] lane_in  [NUM_LANE];
  logic [DATA_W-1:0] lane_out [NUM_LANE];
  logic              lane_flip[NUM_LANE];

  // channel flag: flips on every accepted word
  always_ff @(posedge clk) begin
    if (!rst_n)        chan_q <= CH_A;
    else if (in_valid) chan_q <= (chan_q == CH_A) ? CH_B : CH_A;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    desc_sign_gen #(
      .LFSR_W      (LFSR_W),
      .TAP_MASK    (TAP_MASK),
      .SEED        ((c == 0) ? SEED_A : SEED_B),
      .SYNC_SAMPLES(SYNC_SAMPLES)
    ) i_sign (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (in_valid && (chan_q == chan_e'(c))),
      .sign (sgn[c])
    );
  end

  assign sel = (chan_q == CH_A) ? sgn[0] : sgn[1];

  assign lane_in[0]   = in_re;
  assign lane_in[1]   = in_im;
  assign lane_flip[0] = en & sel.hi;
  assign lane_flip[1] = en & sel.lo;

  for (genvar l = 0; l < NUM_LANE; l++) begin : g_lane
    desc_cond_neg #(.DATA_W(DATA_W)) i_neg (
      .din (lane_in[l]),
      .flip(lane_flip[l]),
      .dout(lane_out[l])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_re <= lane_out[0];
        out_im <= lane_out[1];
      end
    end
  end

  // R2: valid delayed by one cycle
  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3: channel alternates per word
  a_r3_chan_alt: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (chan_q != $past(chan_q)));

  // R7: idle cycles keep channel and outputs
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(chan_q) && $stable(out_re) && $stable(out_im)));

  // R8: bypass passes data untouched
  a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !en) |=> ((out_re == $past(in_re)) && (out_im == $past(in_im))));

  // R9: output is the input or its two's-complement negation
  a_r9_magnitude: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && en) |=>
      (((out_re == $past(in_re)) || (out_re == DATA_W'(0) - $past(in_re))) &&
       ((out_im == $past(in_im)) || (out_im == DATA_W'(0) - $past(in_im)))));

endmodule

// File: tb/test_rand_sign_descrambler.sv
module test_rand_sign_descrambler;
  localparam int          DW   = 8;
  localparam int          SYNC = 12;
  localparam logic [15:0] SA   = 16'hACE1;
  localparam logic [15:0] SB   = 16'h1D2B;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_re = '0;
  logic [DW-1:0] in_im = '0;
  logic          out_valid;
  logic [DW-1:0] out_re;
  logic [DW-1:0] out_im;

  always #4 clk = ~clk;   // 125 MHz

  rand_sign_descrambler #(.DATA_W(DW), .SYNC_SAMPLES(SYNC)) i_rand_sign_descrambler (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid),
    .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [15:0]   m_st [2];
  int            m_cnt [2];
  int            m_word;
  logic [DW-1:0] last_re, last_im;

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [DW-1:0] neg(input logic [DW-1:0] v);
    return DW'(0) - v;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st[0] = SA; m_st[1] = SB; m_cnt[0] = 0; m_cnt[1] = 0; m_word = 0;
    last_re = '0; last_im = '0;
  endtask

  task automatic model_word(output logic hi, output logic lo);
    int ch;
    ch = m_word % 2;
    hi = m_st[ch][15];
    lo = m_st[ch][14];
    if (m_cnt[ch] + 2 == SYNC) begin
      m_st[ch]  = (ch == 0) ? SA : SB;
      m_cnt[ch] = 0;
    end else begin
      m_st[ch]  = nxt(nxt(m_st[ch]));
      m_cnt[ch] = m_cnt[ch] + 2;
    end
    m_word++;
  endtask

  task automatic send(input bit e, input logic [DW-1:0] r, input logic [DW-1:0] i,
                      input logic [DW-1:0] er, input logic [DW-1:0] ei, input string tag);
    @(negedge clk);
    en = e; in_valid = 1'b1; in_re = r; in_im = i;
    @(posedge clk); #1;
    check({tag, " R2 valid"}, {{(DW-1){1'b0}}, out_valid}, {{(DW-1){1'b0}}, 1'b1});
    check({tag, " re"}, out_re, er);
    check({tag, " im"}, out_im, ei);
    last_re = er; last_im = ei;
  endtask

  // original samples -> scrambled word -> expected: original (en=1) or scrambled (en=0)
  task automatic send_scr(input bit e, input logic [DW-1:0] r, input logic [DW-1:0] i, input string tag);
    logic hi, lo;
    logic [DW-1:0] sr, si;
    model_word(hi, lo);
    sr = hi ? neg(r) : r;
    si = lo ? neg(i) : i;
    if (e) send(e, sr, si, r, i, tag);
    else   send(e, sr, si, sr, si, tag);
  endtask

  // raw word: expected is the direct sign application
  task automatic send_raw(input logic [DW-1:0] r, input logic [DW-1:0] i, input string tag);
    logic hi, lo;
    model_word(hi, lo);
    send(1'b1, r, i, hi ? neg(r) : r, lo ? neg(i) : i, tag);
  endtask

  task automatic gap();
    @(negedge clk);
    in_valid = 1'b0; in_re = 8'h5A; in_im = 8'hA5;
    @(posedge clk); #1;
    check("R2 idle valid", {{(DW-1){1'b0}}, out_valid}, '0);
    check("R7 hold re", out_re, last_re);
    check("R7 hold im", out_im, last_im);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 valid", {{(DW-1){1'b0}}, out_valid}, '0);
    check("R1 re", out_re, '0);
    check("R1 im", out_im, '0);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    do_reset();

    // R5 first words from the seeds, R3 R4 R6 R10 across many reseeds with gaps
    for (int k = 0; k < 512; k++) begin
      send_scr(1'b1, DW'(k), DW'(k * 37 + 5), (k < 4) ? "R5 R10" : "R3 R4 R6 R10");
      if (k % 7 == 3) gap();
      if (k % 29 == 11) begin gap(); gap(); end
    end

    // R8 bypass while sequences keep stepping
    for (int k = 0; k < 40; k++) begin
      send_scr(1'b0, DW'(k * 13 + 1), DW'(k * 91 + 7), "R8");
      if (k % 5 == 2) gap();
    end

    // after bypass, descrambling must still be aligned (R8 advance)
    for (int k = 0; k < 30; k++) send_scr(1'b1, DW'(k * 11), DW'(255 - k), "R8 R10");

    // R4 direct sign application and R9 most negative value
    for (int k = 0; k < 30; k++) send_raw(DW'(k * 9 + 3), DW'(k * 5 + 64), "R4");
    for (int k = 0; k < 8; k++) begin
      send_raw(8'h80, 8'h80, "R9");
      check("R9 re stays min", out_re, 8'h80);
      check("R9 im stays min", out_im, 8'h80);
    end

    gap();
    // R1 mid-run reset: channel a again, seeds reloaded
    do_reset();
    for (int k = 0; k < 24; k++) send_scr(1'b1, DW'(k * 3 + 100), DW'(k * 17), "R1 R3 R5");
    gap();

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule